// File: doc/BRIEF.md
# Read/Write Bus Turnaround Scheduler

This block decides, for a memory controller that keeps reads and writes in separate queues, which direction the shared data bus serves. While reads own the bus it watches the write queue; once buffered writes reach a high watermark it switches to write mode, holds reads back, and requests writes one at a time. After every write it checks whether to hand the bus back. Hysteresis comes from a second, lower watermark. Pending reads may cut a write burst short only after the write queue has drained to that low mark. An empty write queue always ends the burst.

On the way back to reads, the block adds the write-to-read turnaround penalty to the bus-busy time. It also keeps a single pending read-service event with its due time. The event is scheduled at the turnaround point and pulled earlier when a read access allows it. For each access it reports the earliest time the next command may be considered. That time is the bus-busy time less the worst-case precharge, activate and column latency, and never earlier than the current time. All queue depths, watermark percentages, timing values and the time width are elaboration parameters.

Top module: `rw_turn_arbiter`

## Requirements
- R1: The high and low entry counts are WR_DEPTH*HI_PCT/100 and WR_DEPTH*LO_PCT/100 with the fraction dropped. With depth 16, 75 % and 25 % they are 12 and 4.
- R2: In read mode, a write occupancy at or above the high count that is also non-zero sets `write_mode` and `reads_stalled` to 1 on the next edge. On the same edge `issue_wr` pulses high for one cycle.
- R3: Each `wr_done` in write mode raises `burst_writes` by one. A `wr_done` in read mode changes neither `burst_writes` nor the mode.
- R4: A `wr_done` in write mode that does not end the burst pulses `issue_wr` on the next edge. Without `wr_done`, no further issue pulse appears.
- R5: A `wr_done` while `wr_count` is 0 ends write mode.
- R6: A `wr_done` ends write mode when `wr_count` is at or below the low count and `rd_count` is non-zero. Pending reads above the low count do not end the burst, and neither does being at the low count with no reads.
- R7: When write mode ends, the next edge clears `write_mode`, `reads_stalled` and `burst_writes` and pulses `resume_rd` for one cycle. The same edge loads `resume_at` with `bus_busy_until` + T_WTR. `resume_at` holds otherwise.
- R8: `burst_at_high` is 1 whenever `burst_writes` is at or above the high count, and reaching that count alone does not end write mode.
- R9: After any cycle with `rd_done` or `wr_done`, `next_req_at` becomes `bus_busy_until` − (T_RP+T_RCD+T_CL) if that difference is greater than `now`, and `now` otherwise. It also becomes `now` when `bus_busy_until` is not greater than the sum. Otherwise it holds.
- R10: When write mode ends and no read event remains pending, the event becomes pending at the new `resume_at` value. An already pending event keeps its time.
- R11: On `rd_done`, a pending event moves to the new next-request time if that is earlier. If no event is pending and reads are not stalled, one becomes pending at that time.
- R12: `evt_ack` clears the pending event. A schedule in the same cycle takes priority over the clear.
- R13: After reset the block is in read mode, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_count | input | $clog2(WR_DEPTH+1) | Write queue occupancy |
| rd_count | input | $clog2(RD_DEPTH+1) | Read queue occupancy |
| wr_done | input | 1 | A write was issued and removed from the queue this cycle |
| rd_done | input | 1 | A read access was performed this cycle |
| evt_ack | input | 1 | The pending read-service event has been taken |
| now | input | TIME_W | Current time in cycles |
| bus_busy_until | input | TIME_W | Time until which the data bus is occupied |
| write_mode | output | 1 | Bus is serving writes |
| reads_stalled | output | 1 | Reads are held back for a write burst |
| issue_wr | output | 1 | One-cycle request to issue the next write |
| resume_rd | output | 1 | One-cycle pulse when the bus returns to reads |
| resume_at | output | TIME_W | Bus-busy time including turnaround, loaded at return to reads |
| burst_writes | output | $clog2(WR_DEPTH+1) | Writes issued in the current burst |
| burst_at_high | output | 1 | Current burst has reached the high count |
| next_req_at | output | TIME_W | Earliest time the next command may be considered |
| rd_evt_pending | output | 1 | A read-service event is pending |
| rd_evt_at | output | TIME_W | Due time of the read-service event |

## Verification
Every output of this block is registered. A change of occupancy, a `wr_done`, an `rd_done` or an `evt_ack` therefore shows up on the first rising edge after the cycle in which it is applied: mode entry and exit, issue and resume pulses, the burst count, the next-request time and the event state all follow this one-edge rule. The driver applies each cycle's inputs on the falling edge. For that same edge it queues the expected output set for the following rising edge, and the monitor compares that set 2 ns after the rising edge, so each result is compared in exactly the cycle it is due. The sequences cover hysteresis with a low watermark of 4. Reads are present while occupancy is still above the mark, then the queue reaches the mark with no reads, and only the combination of both ends the burst.

// File: rtl/rwt_pkg.sv
// Shared types and helpers for the read/write turnaround scheduler.
// Assumes percentages are integers from 0 to 100.
package rwt_pkg;

    typedef enum logic {
        MODE_READ  = 1'b0,
        MODE_WRITE = 1'b1
    } bus_mode_e;

    // Whole number of queue entries for a percentage of a depth, fraction dropped.
    function automatic int pct_entries(input int depth, input int pct);
        return (depth * pct) / 100;
    endfunction

endpackage

// File: rtl/rwt_watermarks.sv
// Watermark comparisons: whether a burst may start, whether the bus may
// leave write mode after a write, and whether the burst reached the high
// count. Purely combinational; assumes LO_PCT <= HI_PCT.
module rwt_watermarks #(
    parameter int WR_DEPTH = 32,
    parameter int RD_DEPTH = 32,
    parameter int HI_PCT   = 70,
    parameter int LO_PCT   = 0,
    localparam int WQW     = $clog2(WR_DEPTH + 1),
    localparam int RQW     = $clog2(RD_DEPTH + 1)
) (
    input  logic [WQW-1:0] wr_count,
    input  logic [RQW-1:0] rd_count,
    input  logic [WQW-1:0] burst_cnt,
    output logic           start_burst,
    output logic           may_leave,
    output logic           burst_at_high
);
    import rwt_pkg::*;

    localparam int             HI_CNT = pct_entries(WR_DEPTH, HI_PCT);
    localparam int             LO_CNT = pct_entries(WR_DEPTH, LO_PCT);
    localparam logic [WQW-1:0] HI_Q   = WQW'(HI_CNT);
    localparam logic [WQW-1:0] LO_Q   = WQW'(LO_CNT);

    logic wr_empty;
    logic rd_waiting;

    // Queue state decode.
    always_comb begin
        wr_empty   = (wr_count == '0);
        rd_waiting = (rd_count != '0);
    end

    // Threshold decisions.
    always_comb begin
        start_burst   = (wr_count >= HI_Q) && !wr_empty;
        may_leave     = wr_empty || ((wr_count <= LO_Q) && rd_waiting);
        burst_at_high = (burst_cnt >= HI_Q);
    end

endmodule

// File: rtl/rwt_drain_fsm.sv
// Bus direction state machine. Enters write mode on a start request, asks
// for one write at a time, counts the writes of the burst and returns to
// reads with a turnaround penalty. Assumes wr_done is a single-cycle strobe
// and that bus_busy_until + T_WTR does not wrap.
module rwt_drain_fsm #(
    parameter int WQW    = 6,
    parameter int TW     = 32,
    parameter int T_WTR  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_burst,
    input  logic                may_leave,
    input  logic                wr_done,
    input  logic [TW-1:0]       bus_busy_until,
    output rwt_pkg::bus_mode_e  mode,
    output logic                issue_wr,
    output logic                resume_rd,
    output logic [TW-1:0]       resume_at,
    output logic [WQW-1:0]      burst_cnt,
    output logic                leave_now,
    output logic [TW-1:0]       leave_time
);
    import rwt_pkg::*;

    localparam logic [TW-1:0] WTR_Q = TW'(T_WTR);

    logic enter_now;
    logic keep_going;

    // Per-cycle decisions from current mode and inputs.
    always_comb begin
        enter_now  = (mode == MODE_READ) && start_burst;
        leave_now  = (mode == MODE_WRITE) && wr_done && may_leave;
        keep_going = (mode == MODE_WRITE) && wr_done && !may_leave;
        leave_time = bus_busy_until + WTR_Q;
    end

    // Mode, pulses, turnaround time and burst counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_READ;
            issue_wr  <= 1'b0;
            resume_rd <= 1'b0;
            resume_at <= '0;
            burst_cnt <= '0;
        end else begin
            issue_wr  <= enter_now || keep_going;
            resume_rd <= leave_now;
            if (enter_now) begin
                mode <= MODE_WRITE;
            end else if (leave_now) begin
                mode <= MODE_READ;
            end
            if (leave_now) begin
                resume_at <= leave_time;
                burst_cnt <= '0;
            end else if (keep_going && (burst_cnt != '1)) begin
                burst_cnt <= burst_cnt + 1'b1;
            end
        end
    end

    assert_issue_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_wr |-> (mode == MODE_WRITE));

    assert_enter_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_READ) && start_burst) |=> ((mode == MODE_WRITE) && issue_wr));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_WRITE) && wr_done && !may_leave && (burst_cnt != '1))
        |=> (burst_cnt == $past(burst_cnt) + 1'b1));

    assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_rd |-> ((burst_cnt == '0) && (mode == MODE_READ)));

    assert_resume_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_WRITE) && wr_done && may_leave)
        |=> (resume_at == $past(bus_busy_until) + WTR_Q));

    assert_stay_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_WRITE) && !wr_done) |=> (mode == MODE_WRITE));

endmodule

// File: rtl/rwt_req_timer.sv
// Next-request time: after any access, the earliest point at which a new
// command may be considered, allowing a worst-case precharge, activate and
// column access before the bus frees up, never before the present time.
module rwt_req_timer #(
    parameter int TW    = 32,
    parameter int T_RP  = 14,
    parameter int T_RCD = 14,
    parameter int T_CL  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_done,
    input  logic          wr_done,
    input  logic [TW-1:0] now,
    input  logic [TW-1:0] bus_busy_until,
    output logic [TW-1:0] cand,
    output logic [TW-1:0] next_req_at
);
    localparam logic [TW-1:0] REACH = TW'(T_RP + T_RCD + T_CL);

    logic [TW-1:0] back;

    // Candidate time, clamped to the present.
    always_comb begin
        back = bus_busy_until - REACH;
        if (bus_busy_until > REACH) begin
            cand = (back > now) ? back : now;
        end else begin
            cand = now;
        end
    end

    // Capture the candidate on every access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_req_at <= '0;
        end else if (rd_done || wr_done) begin
            next_req_at <= cand;
        end
    end

    assert_not_before_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done || wr_done) |=> (next_req_at >= $past(now)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done || wr_done) |=> $stable(next_req_at));

endmodule

// File: rtl/rwt_read_event.sv
// Single pending read-service event. Scheduled at the turnaround point when
// writes end, pulled earlier by read accesses, created by a read access when
// reads are not stalled, and cleared by an acknowledge of lower priority.
module rwt_read_event #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          leave_now,
    input  logic [TW-1:0] leave_time,
    input  logic          rd_done,
    input  logic          stalled,
    input  logic [TW-1:0] cand,
    input  logic          evt_ack,
    output logic          evt_pend,
    output logic [TW-1:0] evt_at
);
    logic pend_eff;

    // Pending state once this cycle's acknowledge is applied.
    always_comb begin
        pend_eff = evt_pend && !evt_ack;
    end

    // Event pending flag and due time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pend <= 1'b0;
            evt_at   <= '0;
        end else if (leave_now) begin
            evt_pend <= 1'b1;
            if (!pend_eff) begin
                evt_at <= leave_time;
            end
        end else if (rd_done) begin
            if (pend_eff) begin
                if (cand < evt_at) begin
                    evt_at <= cand;
                end
            end else if (!stalled) begin
                evt_pend <= 1'b1;
                evt_at   <= cand;
            end else begin
                evt_pend <= 1'b0;
            end
        end else begin
            evt_pend <= pend_eff;
        end
    end

    assert_exit_schedules_R10: assert property (@(posedge clk) disable iff (!rst_n)
        leave_now |=> evt_pend);

    assert_only_earlier_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pend && !evt_ack && rd_done && !leave_now)
        |=> (evt_pend && (evt_at <= $past(evt_at))));

    assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && !leave_now && !rd_done) |=> !evt_pend);

endmodule

// File: rtl/rw_turn_arbiter.sv
// Read/write bus turnaround scheduler. Decides when the data bus leaves
// reads to drain writes and when it returns, requests writes one at a time,
// tracks the next-request time and a pending read-service event.
// Assumes occupancies already reflect any write removed in a wr_done cycle.
module rw_turn_arbiter #(
    parameter int WR_DEPTH = 32,
    parameter int RD_DEPTH = 32,
    parameter int HI_PCT   = 70,
    parameter int LO_PCT   = 0,
    parameter int TIME_W   = 32,
    parameter int T_WTR    = 7,
    parameter int T_RP     = 14,
    parameter int T_RCD    = 14,
    parameter int T_CL     = 14,
    localparam int WQW     = $clog2(WR_DEPTH + 1),
    localparam int RQW     = $clog2(RD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WQW-1:0]    wr_count,
    input  logic [RQW-1:0]    rd_count,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic              evt_ack,
    input  logic [TIME_W-1:0] now,
    input  logic [TIME_W-1:0] bus_busy_until,
    output logic              write_mode,
    output logic              reads_stalled,
    output logic              issue_wr,
    output logic              resume_rd,
    output logic [TIME_W-1:0] resume_at,
    output logic [WQW-1:0]    burst_writes,
    output logic              burst_at_high,
    output logic [TIME_W-1:0] next_req_at,
    output logic              rd_evt_pending,
    output logic [TIME_W-1:0] rd_evt_at
);
    import rwt_pkg::*;

    bus_mode_e          mode;
    logic               start_burst;
    logic               may_leave;
    logic               leave_now;
    logic [TIME_W-1:0]  leave_time;
    logic [TIME_W-1:0]  cand;

    rwt_watermarks #(
        .WR_DEPTH (WR_DEPTH),
        .RD_DEPTH (RD_DEPTH),
        .HI_PCT   (HI_PCT),
        .LO_PCT   (LO_PCT)
    ) u_marks (
        .wr_count      (wr_count),
        .rd_count      (rd_count),
        .burst_cnt     (burst_writes),
        .start_burst   (start_burst),
        .may_leave     (may_leave),
        .burst_at_high (burst_at_high)
    );

    rwt_drain_fsm #(
        .WQW   (WQW),
        .TW    (TIME_W),
        .T_WTR (T_WTR)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_burst    (start_burst),
        .may_leave      (may_leave),
        .wr_done        (wr_done),
        .bus_busy_until (bus_busy_until),
        .mode           (mode),
        .issue_wr       (issue_wr),
        .resume_rd      (resume_rd),
        .resume_at      (resume_at),
        .burst_cnt      (burst_writes),
        .leave_now      (leave_now),
        .leave_time     (leave_time)
    );

    rwt_req_timer #(
        .TW    (TIME_W),
        .T_RP  (T_RP),
        .T_RCD (T_RCD),
        .T_CL  (T_CL)
    ) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_done        (rd_done),
        .wr_done        (wr_done),
        .now            (now),
        .bus_busy_until (bus_busy_until),
        .cand           (cand),
        .next_req_at    (next_req_at)
    );

    rwt_read_event #(
        .TW (TIME_W)
    ) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .leave_now  (leave_now),
        .leave_time (leave_time),
        .rd_done    (rd_done),
        .stalled    (mode == MODE_WRITE),
        .cand       (cand),
        .evt_ack    (evt_ack),
        .evt_pend   (rd_evt_pending),
        .evt_at     (rd_evt_at)
    );

    // Mode indications.
    always_comb begin
        write_mode    = (mode == MODE_WRITE);
        reads_stalled = (mode == MODE_WRITE);
    end

endmodule

// File: tb/rw_turn_arbiter_test.sv
`timescale 1ns/1ps
module rw_turn_arbiter_test;
    localparam int WD = 16, RD = 16, HI = 12, LO = 4, TW = 16;
    localparam int WTR = 6, REACH = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] wr_count = '0, rd_count = '0;
    logic wr_done = 1'b0, rd_done = 1'b0, evt_ack = 1'b0;
    logic [TW-1:0] now = '0, bus_busy_until = '0;
    logic write_mode, reads_stalled, issue_wr, resume_rd, burst_at_high, rd_evt_pending;
    logic [TW-1:0] resume_at, next_req_at, rd_evt_at;
    logic [4:0] burst_writes;

    int total = 0, bad = 0;

    typedef struct packed {
        logic wm; logic iss; logic res; logic [TW-1:0] res_at;
        logic [4:0] burst; logic bhi; logic [TW-1:0] nxt;
        logic pend; logic [TW-1:0] at;
    } exp_t;
    exp_t sb[$];
    string tagq[$];
    exp_t m;

    rw_turn_arbiter #(.WR_DEPTH(WD), .RD_DEPTH(RD), .HI_PCT(75), .LO_PCT(25),
        .TIME_W(TW), .T_WTR(WTR), .T_RP(3), .T_RCD(4), .T_CL(5)) uut (
        .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .rd_count(rd_count),
        .wr_done(wr_done), .rd_done(rd_done), .evt_ack(evt_ack), .now(now),
        .bus_busy_until(bus_busy_until), .write_mode(write_mode),
        .reads_stalled(reads_stalled), .issue_wr(issue_wr), .resume_rd(resume_rd),
        .resume_at(resume_at), .burst_writes(burst_writes), .burst_at_high(burst_at_high),
        .next_req_at(next_req_at), .rd_evt_pending(rd_evt_pending), .rd_evt_at(rd_evt_at));

    always #4 clk = ~clk;

    // Driver: apply one cycle of inputs and queue the expected result of the next edge.
    task automatic drive(input int wc, input int rc, input bit wd, input bit rdv,
                         input bit ack, input int bus, input int nw, input string tag);
        exp_t n;
        int cand;
        bit ext, ent, pe;
        @(negedge clk);
        wr_count = 5'(wc); rd_count = 5'(rc); wr_done = wd; rd_done = rdv;
        evt_ack = ack; bus_busy_until = TW'(bus); now = TW'(nw);
        n = m;
        ent = !m.wm && (wc >= HI) && (wc != 0);
        ext = m.wm && wd && ((wc == 0) || ((wc <= LO) && (rc != 0)));
        cand = (bus > REACH) ? (((bus - REACH) > nw) ? bus - REACH : nw) : nw;
        n.iss = ent || (m.wm && wd && !ext);
        n.res = ext;
        if (ext) n.res_at = TW'(bus + WTR);
        if (ent) n.wm = 1'b1; else if (ext) n.wm = 1'b0;
        if (ext) n.burst = '0; else if (m.wm && wd) n.burst = m.burst + 1'b1;
        n.bhi = (n.burst >= HI);
        if (wd || rdv) n.nxt = TW'(cand);
        pe = m.pend && !ack;
        if (ext) begin
            n.pend = 1'b1;
            if (!pe) n.at = TW'(bus + WTR);
        end else if (rdv) begin
            if (pe) begin
                if (cand < int'(m.at)) n.at = TW'(cand);
            end else if (!m.wm) begin
                n.pend = 1'b1; n.at = TW'(cand);
            end else n.pend = 1'b0;
        end else n.pend = pe;
        m = n;
        sb.push_back(n);
        tagq.push_back(tag);
    endtask

    // Monitor: compare each queued expectation 2 ns after the rising edge.
    always @(posedge clk) begin
        exp_t e;
        string t;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            t = tagq.pop_front();
            total++;
            if (write_mode !== e.wm || reads_stalled !== e.wm || issue_wr !== e.iss ||
                resume_rd !== e.res || resume_at !== e.res_at || burst_writes !== e.burst ||
                burst_at_high !== e.bhi || next_req_at !== e.nxt ||
                rd_evt_pending !== e.pend || rd_evt_at !== e.at) begin
                bad++;
                $display("FAIL %s: got wm=%0d st=%0d iss=%0d res=%0d res_at=%0d burst=%0d hi=%0d nxt=%0d pend=%0d at=%0d exp wm=%0d iss=%0d res=%0d res_at=%0d burst=%0d hi=%0d nxt=%0d pend=%0d at=%0d",
                    t, write_mode, reads_stalled, issue_wr, resume_rd, resume_at, burst_writes,
                    burst_at_high, next_req_at, rd_evt_pending, rd_evt_at,
                    e.wm, e.iss, e.res, e.res_at, e.burst, e.bhi, e.nxt, e.pend, e.at);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 20000);
        bad++;
        $display("FAIL watchdog: got running expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m = '0;
        repeat (3) @(negedge clk);
        // R13: reset state at the ports
        total++;
        if (write_mode || reads_stalled || issue_wr || resume_rd || resume_at != 0 ||
            burst_writes != 0 || burst_at_high || next_req_at != 0 || rd_evt_pending || rd_evt_at != 0) begin
            bad++;
            $display("FAIL R13: got nonzero outputs in reset expected all 0");
        end
        rst_n = 1'b1;
        drive(11, 0, 0, 0, 0, 0, 0, "R2 below high");
        drive(12, 0, 0, 0, 0, 0, 0, "R1 R2 enter at high count");
        drive(12, 0, 0, 0, 0, 0, 0, "R4 no write no issue");
        for (int w = 11; w >= 4; w--) drive(w, 0, 1, 0, 0, 40, 10, "R3 R4 write step");
        drive(7, 3, 1, 0, 0, 40, 12, "R6 reads above low keep burst");
        drive(6, 3, 1, 0, 0, 40, 13, "R6 reads above low keep burst");
        drive(5, 3, 1, 0, 0, 40, 14, "R6 reads above low keep burst");
        drive(4, 0, 1, 0, 0, 40, 15, "R6 R8 at low no reads high flag");
        drive(4, 3, 0, 0, 0, 40, 16, "R8 flag holds no exit");
        drive(4, 3, 1, 0, 0, 100, 60, "R6 R7 R9 R10 exit at low with reads");
        drive(4, 3, 0, 0, 0, 100, 61, "R7 resume single pulse");
        drive(4, 3, 0, 0, 1, 100, 62, "R12 ack clears");
        drive(4, 3, 0, 1, 0, 100, 50, "R11 R9 read sets event");
        drive(4, 3, 0, 1, 0, 90, 80, "R11 R9 move earlier clamp to now");
        drive(4, 3, 0, 1, 0, 10, 70, "R9 R11 bus under reach gives now");
        drive(4, 3, 0, 1, 0, 200, 5, "R11 later time not taken");
        drive(2, 3, 1, 0, 0, 30, 20, "R3 R9 write done in read mode ignored");
        drive(12, 0, 0, 0, 0, 30, 21, "R2 enter again");
        drive(3, 0, 1, 0, 0, 30, 22, "R4 continue at low no reads");
        drive(0, 0, 1, 0, 0, 300, 23, "R5 R10 exit on empty event kept");
        drive(13, 0, 0, 0, 0, 300, 24, "R2 enter third burst");
        drive(0, 2, 1, 0, 1, 400, 25, "R5 R12 exit with ack schedule wins");
        drive(0, 2, 0, 0, 0, 400, 26, "R7 R10 idle after exit");
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule